// File: doc/BRIEF.md
# Serial Host Command Port

This block lets a host microcontroller configure a disc-playback signal processor over three plain wires: a host clock, a data line and an active-low load strobe. The host shifts in a 24-bit word, most significant bit first. The word holds a 16-bit data field followed by an 8-bit command code. The port decodes the word when the load strobe falls. The host wires are sampled by the system clock through a two-stage synchronizer, so the host clock must run well below the system clock.

The port accepts indirect writes of a byte into a small parameter register file, and its contents appear on a flat parameter bus for the processing section. Indirect reads serialize one register byte back out on the status pin. The status pin can also be routed to one of several internal status inputs. A sense flag stays high for a programmable gap after every accepted access, and the host waits for that gap before it issues further transfers or readback clocks. A dedicated address produces a one-cycle reset pulse for the processing section. Indirect accesses are refused until a setup command has been seen.

Top module: `hcp_port`

## Requirements
- R1: A word is 24 bits shifted in MSB first on rising host clock edges while the load strobe is high: data bits D15..D0, then command bits B7..B0. The word is decoded once, when the load strobe falls.
- R2: Command 0xF5 enables indirect access. Before it, commands 0xF2 and 0xF4 leave the registers unchanged and do not raise the sense flag.
- R3: Command 0xF2 writes D7..D0 into the register at address D15..D8 when that address is below NREG. Register n appears on params[8n+7:8n].
- R4: A write to an address at or above NREG changes no register, and a read of such an address returns 0x00.
- R5: Command 0xF4 loads the byte at address D15..D8 into the readback path. The status pin shows the MSB first, each host clock rising edge advances one bit, and after eight bits the pin reads 0.
- R6: Each accepted 0xF2 or 0xF4 holds the sense flag high for GAP_CYC system clocks, then drives it low. Host clock edges during that gap do not advance the readback.
- R7: A 0xF2 write to address 0xAA gives exactly one one-cycle proc_rst pulse, ignores the data byte and changes no register.
- R8: Commands 0x70..0x7B route stat_src[B3..B0] to the status pin and end readback mode.
- R9: Any other command code (for example 0x7C or 0x80) has no effect on registers, the status pin or the sense flag.
- R10: After reset the sense flag is low, all registers are zero, the status pin follows stat_src[0], and indirect access is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clk | input | 1 | Host serial clock |
| host_dat | input | 1 | Host serial data |
| host_ld_n | input | 1 | Active-low load strobe |
| stat_src | input | NSRC | Internal status signals selectable onto the status pin |
| stat_pin | output | 1 | Status pin: the selected source or the readback bit |
| sense | output | 1 | High while the post-access gap runs |
| proc_rst | output | 1 | One-cycle software reset pulse for the processing section |
| params | output | NREG*8 | Flat parameter register contents |

## Verification
The bench sends writes to an implemented address and reads them back, and it also writes and reads unimplemented addresses. A design that decoded the address and data fields in the wrong order, or that let high addresses alias onto low registers, would store or return the wrong byte. It clocks the readback during the busy gap, which catches a design that shifts too early and loses the MSB. It issues writes before the setup command, writes to the software-reset address, and sends a code just past the status-select range. A design that missed any of these rules would change a register, pulse its reset more than once, or move the status pin.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int WORD_W = 24;
  localparam logic [7:0] CMD_WR       = 8'hF2;
  localparam logic [7:0] CMD_RD       = 8'hF4;
  localparam logic [7:0] CMD_SYS      = 8'hF5;
  localparam logic [7:0] CMD_SEL_LO   = 8'h70;
  localparam logic [7:0] CMD_SEL_HI   = 8'h7B;
  localparam logic [7:0] ADDR_SWRST   = 8'hAA;

  typedef enum logic [2:0] {OP_NONE, OP_SYS, OP_WR, OP_RD, OP_SEL} op_e;

  // field order follows the shift order: address byte, data byte, command
  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] cmd;
  } word_t;
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= RST_VAL;
      else if (g == 0) chain[g] <= d;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hcp_shift.sv
module hcp_shift
  import hcp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk,
  input  logic  sdat,
  input  logic  ld_n,
  output word_t word,
  output logic  sclk_rise,
  output logic  ld_fall
);
  logic              sclk_q, ld_q;
  logic [WORD_W-1:0] sr;

  assign sclk_rise = sclk & ~sclk_q;
  assign ld_fall   = ~ld_n & ld_q;
  assign word      = word_t'(sr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ld_q   <= 1'b1;
      sr     <= '0;
    end else begin
      sclk_q <= sclk;
      ld_q   <= ld_n;
      if (sclk_rise && ld_n) sr <= {sr[WORD_W-2:0], sdat};
    end
  end
endmodule

// File: rtl/hcp_regfile.sv
module hcp_regfile #(
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] params
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) params[g*8 +: 8] <= '0;
      else if (wr_en && wr_addr == 8'(g)) params[g*8 +: 8] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == 8'(i)) rd_data = params[i*8 +: 8];
  end
endmodule

// File: rtl/hcp_port.sv
module hcp_port
  import hcp_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int NSRC    = 12,
  parameter int GAP_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_clk,
  input  logic              host_dat,
  input  logic              host_ld_n,
  input  logic [NSRC-1:0]   stat_src,
  output logic              stat_pin,
  output logic              sense,
  output logic              proc_rst,
  output logic [NREG*8-1:0] params
);
  localparam int CW = $clog2(GAP_CYC + 1);

  logic [2:0] sync_q;
  word_t      word;
  logic       sclk_rise, ld_fall;
  op_e        op;
  logic       sys_en, wr_fire, gap_go, busy, rd_mode, src_bit;
  logic [CW-1:0] gap_cnt;
  logic [7:0] rd_data, rd_sr;
  logic [3:0] sel_q;

  hcp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_ld_n, host_clk, host_dat}), .q(sync_q));

  hcp_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(sync_q[1]), .sdat(sync_q[0]),
    .ld_n(sync_q[2]), .word(word), .sclk_rise(sclk_rise), .ld_fall(ld_fall));

  always_comb begin
    op = OP_NONE;
    if (ld_fall) begin
      if (word.cmd == CMD_SYS) op = OP_SYS;
      else if (word.cmd == CMD_WR) op = sys_en ? OP_WR : OP_NONE;
      else if (word.cmd == CMD_RD) op = sys_en ? OP_RD : OP_NONE;
      else if (word.cmd >= CMD_SEL_LO && word.cmd <= CMD_SEL_HI) op = OP_SEL;
    end
  end

  assign wr_fire = (op == OP_WR) && (word.addr != ADDR_SWRST);
  assign gap_go  = (op == OP_WR) || (op == OP_RD);
  assign busy    = (gap_cnt != '0);
  assign sense   = busy;

  hcp_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_addr(word.addr),
    .wr_data(word.data), .rd_addr(word.addr), .rd_data(rd_data), .params(params));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_en   <= 1'b0;
      gap_cnt  <= '0;
      rd_mode  <= 1'b0;
      rd_sr    <= '0;
      sel_q    <= '0;
      proc_rst <= 1'b0;
    end else begin
      proc_rst <= (op == OP_WR) && (word.addr == ADDR_SWRST);
      if (op == OP_SYS) sys_en <= 1'b1;
      if (gap_go) gap_cnt <= CW'(GAP_CYC);
      else if (busy) gap_cnt <= gap_cnt - 1'b1;
      if (op == OP_RD) begin
        rd_mode <= 1'b1;
        rd_sr   <= rd_data;
      end else if (op == OP_SEL) begin
        rd_mode <= 1'b0;
        sel_q   <= word.cmd[3:0];
      end else if (rd_mode && sclk_rise && !busy) begin
        rd_sr <= {rd_sr[6:0], 1'b0};
      end
    end
  end

  always_comb begin
    src_bit = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel_q == 4'(i)) src_bit = stat_src[i];
  end

  assign stat_pin = rd_mode ? rd_sr[7] : src_bit;
endmodule

// File: rtl/hcp_port_chk.sv
module hcp_port_chk #(
  parameter int PW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_fall,
  input logic          sys_en,
  input logic          wr_fire,
  input logic          gap_go,
  input logic          busy,
  input logic          rd_mode,
  input logic          stat_pin,
  input logic          proc_rst,
  input logic [PW-1:0] params
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_en |-> !wr_fire);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(params));

  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_go |=> busy);

  p_rb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && busy && !ld_fall) |=> $stable(stat_pin));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proc_rst |=> !proc_rst);

  p_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proc_rst |-> $stable(params));
endmodule

bind hcp_port hcp_port_chk #(.PW(NREG*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_fall(ld_fall), .sys_en(sys_en),
  .wr_fire(wr_fire), .gap_go(gap_go), .busy(busy), .rd_mode(rd_mode),
  .stat_pin(stat_pin), .proc_rst(proc_rst), .params(params));

// File: tb/hcp_port_test.sv
`timescale 1ns/1ps
module hcp_port_test;
  localparam int NREG = 16;
  localparam int NSRC = 12;
  localparam int GAP  = 64;
  localparam int HP   = 4;

  // {addr, data, expected readback}
  localparam logic [23:0] VEC [6] = '{
    24'h00_5A_5A, 24'h03_A5_A5, 24'h0F_FF_FF,
    24'h07_01_01, 24'h10_77_00, 24'hFE_33_00 };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_clk = 1'b0, host_dat = 1'b0, host_ld_n = 1'b1;
  logic [NSRC-1:0] stat_src = 12'h001;
  logic stat_pin, sense, proc_rst;
  logic [NREG*8-1:0] params;
  int total = 0, fails = 0, pulses = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  hcp_port #(.NREG(NREG), .NSRC(NSRC), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .host_dat(host_dat),
    .host_ld_n(host_ld_n), .stat_src(stat_src), .stat_pin(stat_pin),
    .sense(sense), .proc_rst(proc_rst), .params(params));

  always @(posedge clk) if (rst_n && proc_rst) pulses <= pulses + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clk();
    host_clk = 1'b1; waitc(HP);
    host_clk = 1'b0; waitc(HP);
  endtask

  task automatic send(input logic [7:0] cmd, input logic [15:0] d);
    logic [23:0] w;
    w = {d, cmd};
    for (int i = 23; i >= 0; i--) begin
      host_dat = w[i];
      waitc(HP);
      pulse_clk();
    end
    host_ld_n = 1'b0; waitc(HP);
    host_ld_n = 1'b1; waitc(HP);
  endtask

  task automatic gap();
    waitc(GAP + 10);
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      b[i] = stat_pin;
      pulse_clk();
    end
  endtask

  initial begin
    logic [7:0] b;
    logic [NREG*8-1:0] snap;
    waitc(5);
    rst_n = 1'b1;
    waitc(3);
    // R10 reset state
    chk("R10 sense", sense, 0);
    chk("R10 params", params == '0, 1);
    chk("R10 stat_pin src0", stat_pin, 1);
    // R2 writes refused before setup
    send(8'hF2, 16'h02_99);
    waitc(3);
    chk("R2 no busy", sense, 0);
    chk("R2 no write", params[2*8 +: 8], 8'h00);
    send(8'hF5, 16'h0000);
    // R6 busy gap
    send(8'hF2, 16'h01_11);
    chk("R6 sense high", sense, 1);
    gap();
    chk("R6 sense low", sense, 0);
    chk("R3 write reg1", params[1*8 +: 8], 8'h11);
    // R3/R4/R5 table walk
    for (int i = 0; i < 6; i++) begin
      send(8'hF2, VEC[i][23:8]);
      gap();
      if (VEC[i][23:16] < NREG)
        chk("R3 param bus", params[VEC[i][23:16]*8 +: 8], VEC[i][7:0]);
      else
        chk("R4 no alias", params[VEC[i][19:16]*8 +: 8] == VEC[i][15:8] && VEC[i][19:16] != 4'h1, 0);
      send(8'hF4, {VEC[i][23:16], 8'h00});
      gap();
      read_byte(b);
      chk(VEC[i][23:16] < NREG ? "R5 readback" : "R4 readback zero", b, VEC[i][7:0]);
    end
    // R6 host clocks during gap do not advance readback
    send(8'hF4, 16'h00_00);
    pulse_clk(); pulse_clk(); pulse_clk();
    gap();
    read_byte(b);
    chk("R6 early clocks ignored", b, 8'h5A);
    chk("R5 pin zero after byte", stat_pin, 0);
    // R8 status select, leaving readback mode
    stat_src = 12'h008;
    send(8'h73, 16'h0000);
    waitc(3);
    chk("R8 sel 3 high", stat_pin, 1);
    stat_src = 12'h000;
    waitc(1);
    chk("R8 sel 3 low", stat_pin, 0);
    stat_src = 12'h800;
    send(8'h7B, 16'h0000);
    waitc(3);
    chk("R8 sel 11", stat_pin, 1);
    // R9 codes outside the select range
    stat_src = 12'h008;
    send(8'h73, 16'h0000);
    snap = params;
    send(8'h7C, 16'h0000);
    waitc(3);
    chk("R9 0x7C ignored", stat_pin, 1);
    send(8'h80, 16'h03_00);
    waitc(3);
    chk("R9 0x80 no busy", sense, 0);
    chk("R9 0x80 regs", params == snap, 1);
    chk("R9 0x80 pin", stat_pin, 1);
    // R7 software reset address
    snap = params;
    send(8'hF2, 16'hAA_5A);
    gap();
    chk("R7 one pulse", pulses, 1);
    chk("R7 regs unchanged", params == snap, 1);
    // R1 bits clocked with load low are not shifted
    send(8'hF2, 16'h04_3C);
    gap();
    host_ld_n = 1'b0; waitc(HP);
    host_dat = 1'b1; pulse_clk(); pulse_clk();
    host_ld_n = 1'b1; waitc(HP);
    send(8'hF4, 16'h04_00);
    gap();
    read_byte(b);
    chk("R1 word framing", b, 8'h3C);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule